// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Clock Divider

This block divides a fast clock by a programmable ratio. A dual-modulus prescaler counts either P or P+1 input ticks per prescaler cycle. A swallow counter makes the first A prescaler cycles of every output period use the longer modulus, and the remaining cycles use the shorter one. The main counter closes the period after B prescaler cycles, so one output period lasts P·B + A ticks. An optional halving stage sits in front of the prescaler. When it is selected, the prescaler advances only on every second input cycle, which doubles the output period for the same ratio.

The settings arrive as parallel inputs: A, B, a prescaler choice and the halving select. The block samples them while reset is held and again on the cycle of every output pulse, so a period never mixes old and new settings. The output is a pulse one input cycle wide on the last input cycle of each period. An error flag reports when the applied A was larger than the applied B.

Top module: `pulse_swallow_div`

## Requirements
- R1: While `rst` is high, `div_pulse` is 0 and the settings on the inputs are loaded. The first output period begins on the first cycle after `rst` falls.
- R2: With the halving stage off, `div_pulse` is high on exactly one input cycle of every N = P·B + A input cycles: the last cycle of each period.
- R3: `p_sel` picks the prescaler modulus P as follows: 2'b00 gives 8, 2'b01 gives 16, and both 2'b10 and 2'b11 give 32.
- R4: Every A value from 0 to 31 is honoured. A = 0 gives N = P·B exactly, and A = 31 adds 31 input cycles to the period.
- R5: B values from 3 to 8191 are honoured. B values 0, 1 and 2 are treated as 3.
- R6: If the applied A exceeds the applied (clamped) B, the period uses A = B and `swallow_err` is 1 for that whole period. Otherwise `swallow_err` is 0.
- R7: With `half_sel` = 1, each period lasts 2·(P·B + A) input cycles, and the pulse stays one input cycle wide.
- R8: Input changes in the middle of a period have no effect on that period. They are sampled on the cycle where `div_pulse` is high and govern the next period.
- R9: `div_pulse` is never high on two consecutive input cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 5 | Swallow count A |
| b_in | input | 13 | Main count B |
| p_sel | input | 2 | Prescaler modulus select |
| half_sel | input | 1 | 1 puts the halving stage in front of the prescaler |
| div_pulse | output | 1 | One-cycle pulse on the last cycle of each period |
| swallow_err | output | 1 | The applied A exceeded the applied B |

## Verification
Several properties are checked on every cycle. The prescaler count stays below its current modulus, the main count stays below the clamped B, and the halving stage never produces ticks on back-to-back cycles. The applied settings and the error flag change only after a pulse, and the pulse is never two cycles wide. The exact length of each period is shown only by the bench's scenarios, where a behavioural model follows the inputs and is compared on every clock. These scenarios cover each modulus choice, the extremes of A and B, clamping, A above B, the halving path, and settings that change at arbitrary points in a period.

// File: rtl/pswl_pkg.sv
package pswl_pkg;

   // Prescaler modulus choice; the two upper codes both select the largest modulus.
   typedef enum logic [1:0] {
      PSEL_LO  = 2'b00,
      PSEL_MID = 2'b01,
      PSEL_HI  = 2'b10,
      PSEL_HI2 = 2'b11
   } psel_e;

   // Default field widths of the setting inputs.
   localparam int unsigned SWL_A_W   = 5;
   localparam int unsigned SWL_B_W   = 13;
   localparam int unsigned SWL_B_MIN = 3;

endpackage

// File: rtl/sw_half_stage.sv
module sw_half_stage #(
   parameter bit HALF_EN = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic half_on,
   output logic tick
);

   generate
      if (HALF_EN) begin : g_half
         logic phase_q;

         always_ff @(posedge clk) begin
            if (rst || !half_on) phase_q <= 1'b0;
            else                 phase_q <= ~phase_q;
         end

         assign tick = half_on ? phase_q : 1'b1;

         // R7
         tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
            (half_on && tick) |=> (!half_on || !tick));
      end else begin : g_full
         logic unused_ok;
         assign unused_ok = clk ^ rst ^ half_on;
         assign tick = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/sw_prescaler.sv
module sw_prescaler #(
   parameter int unsigned PC_W = 6
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            tick,
   input  logic [PC_W-1:0] p_base,
   input  logic            stretch,
   output logic            wrap
);

   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] modulus;
   logic            at_end;

   assign modulus = p_base + PC_W'(stretch);
   assign at_end  = (pc_q == modulus - PC_W'(1));
   assign wrap    = tick && at_end;

   always_ff @(posedge clk) begin
      if (rst)               pc_q <= '0;
      else if (tick) begin
         if (at_end)         pc_q <= '0;
         else                pc_q <= pc_q + PC_W'(1);
      end
   end

   // R2
   pc_in_range_chk: assert property (@(posedge clk) disable iff (rst)
      pc_q < modulus);

endmodule

// File: rtl/sw_swallow_ctrl.sv
module sw_swallow_ctrl #(
   parameter int unsigned B_W = 13
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           wrap,
   input  logic [B_W-1:0] a_eff,
   input  logic [B_W-1:0] b_eff,
   output logic           stretch,
   output logic           period_end
);

   logic [B_W-1:0] bc_q;
   logic           last_cycle;

   assign stretch    = (bc_q < a_eff);
   assign last_cycle = (bc_q == b_eff - B_W'(1));
   assign period_end = wrap && last_cycle;

   always_ff @(posedge clk) begin
      if (rst)             bc_q <= '0;
      else if (wrap) begin
         if (last_cycle)   bc_q <= '0;
         else              bc_q <= bc_q + B_W'(1);
      end
   end

   // R5
   bc_in_range_chk: assert property (@(posedge clk) disable iff (rst)
      bc_q < b_eff);

   // R2
   restart_chk: assert property (@(posedge clk) disable iff (rst)
      period_end |=> (bc_q == '0));

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
   import pswl_pkg::*;
#(
   parameter int unsigned A_W     = SWL_A_W,
   parameter int unsigned B_W     = SWL_B_W,
   parameter int unsigned B_MIN   = SWL_B_MIN,
   parameter int unsigned P_LO    = 8,
   parameter int unsigned P_MID   = 16,
   parameter int unsigned P_HI    = 32,
   parameter bit          HALF_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [A_W-1:0] a_in,
   input  logic [B_W-1:0] b_in,
   input  logic [1:0]     p_sel,
   input  logic           half_sel,
   output logic           div_pulse,
   output logic           swallow_err
);

   localparam int unsigned PC_W = $clog2(P_HI + 2);

   generate
      if (P_LO < 2)                         $error("P_LO must be at least 2");
      if (!(P_LO < P_MID && P_MID < P_HI))  $error("moduli must be strictly increasing");
      if (A_W > B_W)                        $error("A_W must not exceed B_W");
      if (B_MIN < 1 || B_MIN >= (1 << B_W)) $error("B_MIN out of range");
   endgenerate

   // Applied settings, held for a whole period.
   logic [B_W-1:0]  cfg_a_q, cfg_b_q;
   logic [PC_W-1:0] cfg_p_q;
   logic            cfg_half_q, cfg_err_q;

   // Candidate settings derived from the inputs.
   logic [B_W-1:0]  b_clamp, a_ext, a_pick;
   logic [PC_W-1:0] p_pick;
   logic            a_over;

   logic tick, wrap, stretch, period_end, load;

   assign b_clamp = (b_in < B_W'(B_MIN)) ? B_W'(B_MIN) : b_in;
   assign a_ext   = B_W'(a_in);
   assign a_over  = (a_ext > b_clamp);
   assign a_pick  = a_over ? b_clamp : a_ext;

   always_comb begin
      unique case (psel_e'(p_sel))
         PSEL_LO:  p_pick = PC_W'(P_LO);
         PSEL_MID: p_pick = PC_W'(P_MID);
         default:  p_pick = PC_W'(P_HI);
      endcase
   end

   assign load = rst || period_end;

   always_ff @(posedge clk) begin
      if (load) begin
         cfg_a_q    <= a_pick;
         cfg_b_q    <= b_clamp;
         cfg_p_q    <= p_pick;
         cfg_half_q <= half_sel;
         cfg_err_q  <= a_over;
      end
   end

   sw_half_stage #(.HALF_EN(HALF_EN)) u_half (
      .clk     (clk),
      .rst     (rst),
      .half_on (cfg_half_q),
      .tick    (tick)
   );

   sw_prescaler #(.PC_W(PC_W)) u_pre (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .p_base  (cfg_p_q),
      .stretch (stretch),
      .wrap    (wrap)
   );

   sw_swallow_ctrl #(.B_W(B_W)) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .wrap       (wrap),
      .a_eff      (cfg_a_q),
      .b_eff      (cfg_b_q),
      .stretch    (stretch),
      .period_end (period_end)
   );

   assign div_pulse   = period_end && !rst;
   assign swallow_err = cfg_err_q;

   // R9
   pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
      div_pulse |=> !div_pulse);

   // R8
   cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !div_pulse |=> $stable({cfg_a_q, cfg_b_q, cfg_p_q, cfg_half_q}));

   // R6
   err_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !div_pulse |=> $stable(swallow_err));

   // R6
   a_bound_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_a_q <= cfg_b_q);

endmodule

// File: tb/pulse_swallow_div_test.sv
module pulse_swallow_div_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  a_in = 5'd5;
   logic [12:0] b_in = 13'd10;
   logic [1:0]  p_sel = 2'b00;
   logic        half_sel = 1'b0;
   logic        div_pulse, swallow_err;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   string tag = "R2";

   // Behavioural reference state.
   int  m_cnt = 0;
   int  m_period = 1;
   bit  m_err = 1'b0;
   bit  m_valid = 1'b0;
   bit  prev_pulse = 1'b0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   pulse_swallow_div uut (
      .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
      .p_sel(p_sel), .half_sel(half_sel),
      .div_pulse(div_pulse), .swallow_err(swallow_err)
   );

   function automatic int calc_period(int a, int b, int ps, bit h, output bit e);
      int p, bc, ae;
      p  = (ps == 0) ? 8 : (ps == 1) ? 16 : 32;
      bc = (b < 3) ? 3 : b;
      e  = (a > bc);
      ae = e ? bc : a;
      return (p * bc + ae) * (h ? 2 : 1);
   endfunction

   always @(posedge clk) begin
      bit e;
      cyc++;
      if (rst || (m_valid && m_cnt == m_period - 1)) begin
         m_period = calc_period(a_in, b_in, p_sel, half_sel, e);
         m_err    = e;
         m_cnt    = 0;
         m_valid  = 1'b1;
      end else begin
         m_cnt++;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         if (rst) begin
            checks++;
            if (div_pulse !== 1'b0) begin
               errors++;
               $display("FAIL R1 pulse in reset: got %b expected 0", div_pulse);
            end
         end else if (m_valid) begin
            bit exp_p;
            exp_p = (m_cnt == m_period - 1);
            checks++;
            if (div_pulse !== exp_p) begin
               errors++;
               $display("FAIL %s pulse at cycle %0d: got %b expected %b", tag, cyc, div_pulse, exp_p);
            end
            checks++;
            if (swallow_err !== m_err) begin
               errors++;
               $display("FAIL %s err at cycle %0d: got %b expected %b", tag, cyc, swallow_err, m_err);
            end
            if (div_pulse) begin
               checks++;
               if (prev_pulse) begin
                  errors++;
                  $display("FAIL R9 pulse wide at cycle %0d: got 1 expected 0", cyc);
               end
            end
         end
         prev_pulse = div_pulse;
      end
   end

   task automatic run(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic set_cfg(int a, int b, int ps, bit h);
      a_in = 5'(a); b_in = 13'(b); p_sel = 2'(ps); half_sel = h;
   endtask

   task automatic finish_up();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      // R1: hold reset, loads settings and keeps the pulse low
      tag = "R1";
      run(4);
      checks++;
      if (swallow_err !== 1'b0) begin
         errors++;
         $display("FAIL R1 err after reset load: got %b expected 0", swallow_err);
      end
      rst = 1'b0;
      // R2: plain ratio 8*10+5 = 85
      tag = "R2";
      run(400);
      // R3: each modulus code
      tag = "R3";
      set_cfg(3, 4, 1, 0);  run(300);
      set_cfg(2, 5, 2, 0);  run(500);
      set_cfg(7, 6, 3, 0);  run(600);
      // R4: extremes of A
      tag = "R4";
      set_cfg(0, 40, 0, 0);  run(800);
      set_cfg(31, 40, 0, 0); run(900);
      // R5: smallest, clamped and large B
      tag = "R5";
      set_cfg(0, 3, 0, 0);   run(200);
      set_cfg(1, 0, 0, 0);   run(200);
      set_cfg(2, 2, 1, 0);   run(300);
      set_cfg(9, 300, 0, 0); run(5200);
      // R6: A above B
      tag = "R6";
      set_cfg(20, 5, 0, 0);  run(300);
      set_cfg(31, 1, 1, 0);  run(300);
      set_cfg(4, 5, 0, 0);   run(300);
      // R7: halving path
      tag = "R7";
      set_cfg(5, 10, 0, 1);  run(700);
      set_cfg(31, 3, 2, 1);  run(800);
      set_cfg(0, 7, 1, 1);   run(800);
      // R8: settings moved at odd points inside periods
      tag = "R8";
      for (int i = 0; i < 60; i++) begin
         set_cfg((i * 7) % 32, 3 + (i * 5) % 12, i % 4, i[1]);
         run(7 + (i % 13));
      end
      run(2000);
      // R1: reset again mid-period
      tag = "R1";
      set_cfg(6, 9, 1, 0);
      rst = 1'b1; run(3);
      rst = 1'b0;
      tag = "R2";
      run(700);
      finish_up();
   end

   initial begin
      #(4 * 190000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
   end

endmodule